// File: doc/BRIEF.md
# UART Register Front End with Transmit and Receive Queues

This block is the software-facing side of a serial port. A 32-bit word bus reaches six registers: a transmit queue port, a receive queue port, a control word, a status word, an interrupt threshold word and a baud configuration word. Bytes written to the transmit port wait in a FIFO until a separate serial engine takes them over a valid/ready stream. Bytes the engine receives are pushed into a second FIFO and read back by software through the receive port, which pops one byte on each read.

Parity, framing and overflow errors are held in sticky flags. They are cleared only by a level-sensitive clear bit in the control word, which software raises and then lowers. Each FIFO can be flushed the same way. One interrupt line combines a receive condition (fill level at or above a programmable count) and a transmit condition (fill level below a programmable count), each with its own enable. The baud word is only stored and passed to the engine. Bit timing happens outside this block.

Top module: `uart_csr_front`

## Requirements
- R1: After reset the control, threshold and baud registers read 0. The status word reads 0x0050_0000: receive-empty is bit 20, transmit-empty is bit 22, and all other bits are 0. `irq` and `tx_valid` are low and `tx_idle` is high.
- R2: The registers sit at these byte addresses: transmit queue 0x00, receive queue 0x04, control 0x08, status 0x0C, thresholds 0x10, baud 0x14. The control register keeps only bits 12, 13, 22, 23, 24, 27 and 28, and the others read 0. The threshold register keeps bits 15:0. The baud register keeps all 32 bits and drives `baud_cfg`.
- R3: A write to 0x00 pushes bits 7:0 into the transmit FIFO. `tx_valid` is high only while control bit 12 (transmit enable) is set and the FIFO is not empty. Bytes leave on `tx_data` in write order, one per cycle with `tx_valid` and `tx_ready` both high.
- R4: With DEPTH bytes queued, status bit 21 (transmit full) is set. A further write to 0x00 is dropped and sets status bit 18 (overflow).
- R5: `rx_valid` pushes `rx_data` only while control bit 13 (receive enable) is set, and is ignored otherwise. A read of 0x04 returns the oldest byte in bits 7:0 with bits 31:8 zero, and pops it.
- R6: A receive push into a full receive FIFO is dropped and sets status bit 18. The stored bytes are unchanged.
- R7: An accepted receive push with `rx_par_err` sets status bit 16. With `rx_frm_err` it sets status bit 17.
- R8: Error bits 16, 17 and 18 stay set until control bit 24 is written 1. While bit 24 is 1 the flags read 0 and new errors are not recorded. After bit 24 is written back to 0 the flags stay 0.
- R9: While control bit 22 is 1 the transmit FIFO is held empty and writes to 0x00 are dropped without setting overflow. While control bit 23 is 1 the receive FIFO is held empty in the same way.
- R10: Status bit 25 follows the `tx_busy` input. `tx_idle` is high only when the transmit FIFO is empty and `tx_busy` is low.
- R11: The receive interrupt is active when control bit 27 is set and the receive fill level is at or above threshold bits 7:0.
- R12: The transmit interrupt is active when control bit 28 is set and the transmit fill level is below threshold bits 15:8. `irq` is the OR of the two interrupts.
- R13: A read of 0x04 while the receive FIFO is empty returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit byte available and transmit enabled |
| tx_ready | input | 1 | Engine takes the byte this cycle |
| tx_busy | input | 1 | Engine is still shifting a frame |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Push received byte |
| rx_par_err | input | 1 | Parity error on the pushed byte |
| rx_frm_err | input | 1 | Framing error on the pushed byte |
| baud_cfg | output | 32 | Stored baud configuration word |
| tx_idle | output | 1 | Transmit FIFO empty and engine not busy |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `bus_req` lasts one cycle per access and that `rx_par_err` and `rx_frm_err` mean something only while `rx_valid` is high. They also assume `tx_busy` comes from a synchronous source. The bench drives every input one half-cycle away from the sampling edge and holds each access for exactly one cycle. It raises the error inputs only together with `rx_valid`, and it changes `tx_busy` only between accesses.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  // Byte offsets of the registers.
  localparam int OFS_TXQ  = 'h00;
  localparam int OFS_RXQ  = 'h04;
  localparam int OFS_CTL  = 'h08;
  localparam int OFS_STS  = 'h0C;
  localparam int OFS_THR  = 'h10;
  localparam int OFS_BAUD = 'h14;

  // Control bit positions.
  localparam int CB_TXEN   = 12;
  localparam int CB_RXEN   = 13;
  localparam int CB_TXRST  = 22;
  localparam int CB_RXRST  = 23;
  localparam int CB_ERRCLR = 24;
  localparam int CB_RXIE   = 27;
  localparam int CB_TXIE   = 28;

  // Status bit positions.
  localparam int SB_PAR  = 16;
  localparam int SB_FRM  = 17;
  localparam int SB_OVF  = 18;
  localparam int SB_RXE  = 20;
  localparam int SB_TXF  = 21;
  localparam int SB_TXE  = 22;
  localparam int SB_BUSY = 25;

  localparam int THR_W = 8;

  typedef struct packed {
    logic ovf;
    logic frm;
    logic par;
  } err_t;

  function automatic logic [31:0] ctl_mask();
    logic [31:0] m;
    m = '0;
    m[CB_TXEN]   = 1'b1;
    m[CB_RXEN]   = 1'b1;
    m[CB_TXRST]  = 1'b1;
    m[CB_RXRST]  = 1'b1;
    m[CB_ERRCLR] = 1'b1;
    m[CB_RXIE]   = 1'b1;
    m[CB_TXIE]   = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] pack_status(err_t e, logic rx_empty,
                                              logic tx_full, logic tx_empty,
                                              logic busy);
    logic [31:0] s;
    s = '0;
    s[SB_PAR]  = e.par;
    s[SB_FRM]  = e.frm;
    s[SB_OVF]  = e.ovf;
    s[SB_RXE]  = rx_empty;
    s[SB_TXF]  = tx_full;
    s[SB_TXE]  = tx_empty;
    s[SB_BUSY] = busy;
    return s;
  endfunction

  // Receive side fires once the level reaches the count.
  function automatic logic rx_reached(logic [15:0] level, logic [15:0] count);
    return level >= count;
  endfunction

  // Transmit side fires while the level sits under the count.
  function automatic logic tx_starved(logic [15:0] level, logic [15:0] count);
    return level < count;
  endfunction

endpackage

// File: rtl/csr_fifo.sv
module csr_fifo #(
  parameter  int DEPTH = 64,
  parameter  int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             push_drop
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push && !full && !flush;
  assign push_drop = push && full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/csr_err_latch.sv
module csr_err_latch
  import uart_csr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  err_t set,
  output err_t flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (clr) flags <= '0;
    else          flags <= flags | set;
  end

endmodule

// File: rtl/csr_irq_gen.sv
module csr_irq_gen
  import uart_csr_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             rx_ie,
  input  logic             tx_ie,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [THR_W-1:0] rx_count,
  input  logic [THR_W-1:0] tx_count,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             irq
);

  assign rx_irq = rx_ie && rx_reached(16'(rx_level), 16'(rx_count));
  assign tx_irq = tx_ie && tx_starved(16'(tx_level), 16'(tx_count));
  assign irq    = rx_irq || tx_irq;

endmodule

// File: rtl/uart_csr_front.sv
module uart_csr_front
  import uart_csr_pkg::*;
#(
  parameter  int DEPTH  = 64,
  parameter  int ADDR_W = 5,
  parameter  int DATA_W = 8,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic              tx_busy,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  output logic [31:0]       baud_cfg,
  output logic              tx_idle,
  output logic              irq
);

  localparam logic [31:0] CTL_MASK = ctl_mask();

  logic [31:0]      ctl_q;
  logic [15:0]      thr_q;
  logic [31:0]      baud_q;

  // Decoded bus events.
  logic ev_wr, ev_rd;
  logic ev_txq_wr, ev_rxq_rd, ev_ctl_wr, ev_thr_wr, ev_baud_wr;

  // Control fields.
  logic ctl_txen, ctl_rxen, tx_flush, rx_flush, err_clr, rx_ie, tx_ie;

  // FIFO state.
  logic [DATA_W-1:0] tx_head, rx_head;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_push_ok, tx_drop, rx_push, rx_push_ok, rx_drop, tx_pop;

  err_t err_set, err_q;
  logic rx_irq, tx_irq;

  assign ev_wr      = bus_req && bus_we;
  assign ev_rd      = bus_req && !bus_we;
  assign ev_txq_wr  = ev_wr && (bus_addr == ADDR_W'(OFS_TXQ));
  assign ev_ctl_wr  = ev_wr && (bus_addr == ADDR_W'(OFS_CTL));
  assign ev_thr_wr  = ev_wr && (bus_addr == ADDR_W'(OFS_THR));
  assign ev_baud_wr = ev_wr && (bus_addr == ADDR_W'(OFS_BAUD));
  assign ev_rxq_rd  = ev_rd && (bus_addr == ADDR_W'(OFS_RXQ));

  assign ctl_txen = ctl_q[CB_TXEN];
  assign ctl_rxen = ctl_q[CB_RXEN];
  assign tx_flush = ctl_q[CB_TXRST];
  assign rx_flush = ctl_q[CB_RXRST];
  assign err_clr  = ctl_q[CB_ERRCLR];
  assign rx_ie    = ctl_q[CB_RXIE];
  assign tx_ie    = ctl_q[CB_TXIE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      thr_q  <= '0;
      baud_q <= '0;
    end else begin
      if (ev_ctl_wr)  ctl_q  <= bus_wdata & CTL_MASK;
      if (ev_thr_wr)  thr_q  <= bus_wdata[15:0];
      if (ev_baud_wr) baud_q <= bus_wdata;
    end
  end

  assign tx_valid = ctl_txen && !tx_empty;
  assign tx_pop   = tx_valid && tx_ready;
  assign tx_data  = tx_head;

  csr_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) i_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .push      (ev_txq_wr),
    .push_data (bus_wdata[DATA_W-1:0]),
    .pop       (tx_pop),
    .head      (tx_head),
    .count     (tx_cnt),
    .full      (tx_full),
    .empty     (tx_empty),
    .push_ok   (tx_push_ok),
    .push_drop (tx_drop)
  );

  assign rx_push = rx_valid && ctl_rxen;

  csr_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) i_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (rx_push),
    .push_data (rx_data),
    .pop       (ev_rxq_rd),
    .head      (rx_head),
    .count     (rx_cnt),
    .full      (rx_full),
    .empty     (rx_empty),
    .push_ok   (rx_push_ok),
    .push_drop (rx_drop)
  );

  assign err_set.par = rx_push_ok && rx_par_err;
  assign err_set.frm = rx_push_ok && rx_frm_err;
  assign err_set.ovf = tx_drop || rx_drop;

  csr_err_latch i_err (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (err_clr),
    .set   (err_set),
    .flags (err_q)
  );

  csr_irq_gen #(.CNT_W(CNT_W)) i_irq (
    .rx_ie    (rx_ie),
    .tx_ie    (tx_ie),
    .rx_level (rx_cnt),
    .tx_level (tx_cnt),
    .rx_count (thr_q[THR_W-1:0]),
    .tx_count (thr_q[2*THR_W-1:THR_W]),
    .rx_irq   (rx_irq),
    .tx_irq   (tx_irq),
    .irq      (irq)
  );

  assign baud_cfg = baud_q;
  assign tx_idle  = tx_empty && !tx_busy;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_RXQ):  bus_rdata = rx_empty ? '0 : 32'(rx_head);
      ADDR_W'(OFS_CTL):  bus_rdata = ctl_q;
      ADDR_W'(OFS_STS):  bus_rdata = pack_status(err_q, rx_empty, tx_full,
                                                 tx_empty, tx_busy);
      ADDR_W'(OFS_THR):  bus_rdata = 32'(thr_q);
      ADDR_W'(OFS_BAUD): bus_rdata = baud_q;
      default:           bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_csr_front_chk.sv
module uart_csr_front_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_txq_wr,
  input logic             ev_rxq_rd,
  input logic             tx_full,
  input logic             tx_empty,
  input logic             tx_flush,
  input logic             rx_flush,
  input logic             err_clr,
  input logic             err_par,
  input logic             err_ovf,
  input logic             ctl_txen,
  input logic             ctl_rxen,
  input logic             tx_valid,
  input logic             rx_valid,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             rx_ie,
  input logic             tx_ie,
  input logic             irq,
  input logic             tx_busy,
  input logic             tx_idle
);

  p_disabled_no_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_txen |-> !tx_valid);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_txq_wr && tx_full && !tx_flush && !err_clr) |=> err_ovf);

  p_rx_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ctl_rxen && !ev_rxq_rd && !rx_flush) |=> $stable(rx_cnt));

  p_rx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(DEPTH));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_par && !err_clr) |=> err_par);

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (!err_par && !err_ovf));

  p_tx_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_empty);

  p_busy_not_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_idle);

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ie && !tx_ie) |-> !irq);

endmodule

bind uart_csr_front uart_csr_front_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_txq_wr (ev_txq_wr),
  .ev_rxq_rd (ev_rxq_rd),
  .tx_full   (tx_full),
  .tx_empty  (tx_empty),
  .tx_flush  (tx_flush),
  .rx_flush  (rx_flush),
  .err_clr   (err_clr),
  .err_par   (err_q.par),
  .err_ovf   (err_q.ovf),
  .ctl_txen  (ctl_txen),
  .ctl_rxen  (ctl_rxen),
  .tx_valid  (tx_valid),
  .rx_valid  (rx_valid),
  .rx_cnt    (rx_cnt),
  .rx_ie     (rx_ie),
  .tx_ie     (tx_ie),
  .irq       (irq),
  .tx_busy   (tx_busy),
  .tx_idle   (tx_idle)
);

// File: tb/test_uart_csr_front.sv
module test_uart_csr_front;

  localparam int DEPTH = 64;

  // Bit values taken from the requirements.
  localparam logic [31:0] S_PAR  = 32'h0001_0000;
  localparam logic [31:0] S_FRM  = 32'h0002_0000;
  localparam logic [31:0] S_OVF  = 32'h0004_0000;
  localparam logic [31:0] S_RXE  = 32'h0010_0000;
  localparam logic [31:0] S_TXF  = 32'h0020_0000;
  localparam logic [31:0] S_TXE  = 32'h0040_0000;
  localparam logic [31:0] S_BUSY = 32'h0200_0000;
  localparam logic [31:0] C_TXEN = 32'h0000_1000;
  localparam logic [31:0] C_RXEN = 32'h0000_2000;
  localparam logic [31:0] C_TRST = 32'h0040_0000;
  localparam logic [31:0] C_RRST = 32'h0080_0000;
  localparam logic [31:0] C_CLR  = 32'h0100_0000;
  localparam logic [31:0] C_RXIE = 32'h0800_0000;
  localparam logic [31:0] C_TXIE = 32'h1000_0000;

  typedef struct packed {
    logic        we;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 5'h08, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 5'h08, 32'h0,         32'h19C0_3000},
    '{1'b1, 5'h08, 32'h0,         32'h0},
    '{1'b0, 5'h08, 32'h0,         32'h0},
    '{1'b1, 5'h10, 32'hABCD_1234, 32'h0},
    '{1'b0, 5'h10, 32'h0,         32'h0000_1234},
    '{1'b1, 5'h14, 32'hC080_1234, 32'h0},
    '{1'b0, 5'h14, 32'h0,         32'hC080_1234},
    '{1'b0, 5'h0C, 32'h0,         32'h0050_0000},
    '{1'b0, 5'h00, 32'h0,         32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  tx_data, rx_data = '0;
  logic        tx_valid, tx_ready = 1'b0, tx_busy = 1'b0;
  logic        rx_valid = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
  logic [31:0] baud_cfg;
  logic        tx_idle, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_csr_front #(.DEPTH(DEPTH)) i_uart_csr_front (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b, input logic pe, input logic fe);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_par_err = pe; rx_frm_err = fe;
    @(negedge clk);
    rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
  endtask

  task automatic tx_take(input logic [7:0] exp);
    @(negedge clk);
    chk("R3 tx_valid", 32'(tx_valid), 32'd1);
    chk("R3 tx_data order", 32'(tx_data), 32'(exp));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h0C, v); chk("R1 status", v, S_RXE | S_TXE);
    rd(5'h08, v); chk("R1 control", v, 32'h0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 tx_valid", 32'(tx_valid), 32'd0);
    chk("R1 tx_idle", 32'(tx_idle), 32'd1);

    // R2 register map walk
    foreach (VECS[i]) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, v);
        chk("R2 readback", v, VECS[i].exp);
      end
    end
    chk("R2 baud_cfg", baud_cfg, 32'hC080_1234);
    wr(5'h10, 32'h0);

    // R3 transmit order and enable gating
    wr(5'h00, 32'hFFFF_FF11); wr(5'h00, 32'h22); wr(5'h00, 32'h33);
    chk("R3 disabled tx_valid", 32'(tx_valid), 32'd0);
    wr(5'h08, C_TXEN);
    tx_take(8'h11); tx_take(8'h22); tx_take(8'h33);
    @(negedge clk);
    chk("R3 drained", 32'(tx_valid), 32'd0);

    // R4 transmit full and overflow
    wr(5'h08, 32'h0);
    for (int k = 0; k < DEPTH; k++) wr(5'h00, 32'(k));
    rd(5'h0C, v); chk("R4 full flag", v, S_RXE | S_TXF);
    wr(5'h00, 32'hEE);
    rd(5'h0C, v); chk("R4 overflow", v, S_RXE | S_TXF | S_OVF);

    // R8 clear then release
    wr(5'h08, C_CLR);
    rd(5'h0C, v); chk("R8 cleared while high", v & (S_PAR | S_FRM | S_OVF), 32'h0);
    wr(5'h08, 32'h0);
    rd(5'h0C, v); chk("R8 cleared after low", v & (S_PAR | S_FRM | S_OVF), 32'h0);

    // R9 transmit flush held
    wr(5'h08, C_TRST);
    wr(5'h00, 32'h55);
    rd(5'h0C, v); chk("R9 tx flush", v, S_RXE | S_TXE);
    wr(5'h08, 32'h0);

    // R5 receive path, R13 empty read
    wr(5'h08, C_RXEN);
    rx_push(8'h5A, 1'b0, 1'b0); rx_push(8'hA5, 1'b0, 1'b0);
    rd(5'h04, v); chk("R5 first byte", v, 32'h5A);
    rd(5'h04, v); chk("R5 second byte", v, 32'hA5);
    rd(5'h04, v); chk("R13 empty read", v, 32'h0);
    rd(5'h0C, v); chk("R13 state unchanged", v, S_RXE | S_TXE);
    wr(5'h08, 32'h0);
    rx_push(8'h77, 1'b0, 1'b0);
    rd(5'h0C, v); chk("R5 disabled push ignored", v, S_RXE | S_TXE);

    // R7 error flags, R8 stickiness and clear
    wr(5'h08, C_RXEN);
    rx_push(8'h01, 1'b1, 1'b0);
    rd(5'h0C, v); chk("R7 parity", v & (S_PAR | S_FRM), S_PAR);
    rx_push(8'h02, 1'b0, 1'b1);
    rd(5'h0C, v); chk("R7 framing", v & (S_PAR | S_FRM), S_PAR | S_FRM);
    rx_push(8'h03, 1'b0, 1'b0);
    rd(5'h0C, v); chk("R8 sticky", v & (S_PAR | S_FRM), S_PAR | S_FRM);
    wr(5'h08, C_RXEN | C_CLR);
    rx_push(8'h04, 1'b1, 1'b1);
    wr(5'h08, C_RXEN);
    rd(5'h0C, v); chk("R8 no record while clearing", v & (S_PAR | S_FRM | S_OVF), 32'h0);

    // R9 receive flush
    wr(5'h08, C_RRST);
    rd(5'h0C, v); chk("R9 rx flush", v & S_RXE, S_RXE);

    // R6 receive overflow
    wr(5'h08, C_RXEN);
    for (int k = 0; k < DEPTH; k++) rx_push(8'(k + 8'h40), 1'b0, 1'b0);
    rx_push(8'hFF, 1'b0, 1'b0);
    rd(5'h0C, v); chk("R6 overflow", v & S_OVF, S_OVF);
    rd(5'h04, v); chk("R6 oldest kept", v, 32'h40);
    wr(5'h08, C_RRST | C_CLR);
    wr(5'h08, 32'h0);

    // R11 receive interrupt
    wr(5'h10, 32'h0000_0203);
    wr(5'h08, C_RXEN | C_RXIE);
    rx_push(8'h10, 1'b0, 1'b0); rx_push(8'h11, 1'b0, 1'b0);
    chk("R11 below count", 32'(irq), 32'd0);
    rx_push(8'h12, 1'b0, 1'b0);
    chk("R11 at count", 32'(irq), 32'd1);
    rd(5'h04, v);
    chk("R11 after pop", 32'(irq), 32'd0);
    wr(5'h08, C_RRST);

    // R12 transmit interrupt
    wr(5'h08, C_TXIE);
    chk("R12 empty below count", 32'(irq), 32'd1);
    wr(5'h00, 32'h1); wr(5'h00, 32'h2);
    chk("R12 at count", 32'(irq), 32'd0);

    // R10 busy and idle
    chk("R10 idle with data", 32'(tx_idle), 32'd0);
    wr(5'h08, C_TRST);
    wr(5'h08, 32'h0);
    chk("R10 idle", 32'(tx_idle), 32'd1);
    @(negedge clk) tx_busy = 1'b1;
    rd(5'h0C, v); chk("R10 busy bit", v & S_BUSY, S_BUSY);
    chk("R10 busy not idle", 32'(tx_idle), 32'd0);
    @(negedge clk) tx_busy = 1'b0;

    finish_run();
  end

endmodule